// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address path in front of a synchronous burst memory. On a load command it captures a full word address, the read/write type of the access and the burst order. On each later advance command it steps only the two least significant address bits through a four-word block, in either linear or interleaved order. The upper address bits stay fixed for the whole burst.

One strobe input selects between the two commands. When it is low at an enabled clock edge, a new base address is loaded. This happens only if every chip-select input is active. If any chip-select input is inactive, the load is taken as a deselect. When the strobe is high, the burst advances, and the chip selects and the write enable are not looked at. When the active-low clock enable is high, every internal state holds. The outputs give the current word address, the latched access type and a flag that says whether a valid burst is in progress.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `burst_act` is 0, `acc_write` is 0 and `word_addr` is 0.
- R2: At an edge with `clk_en_n`=0, `adv_nload`=0 and every bit of `sel_act`=1, the next cycle shows `burst_act`=1 and `word_addr` equal to the `addr_in` sampled at that edge.
- R3: At an edge with `clk_en_n`=0 and `adv_nload`=0, if any bit of `sel_act` is 0 (a deselect), the next cycle shows `burst_act`=0.
- R4: With `order_sel`=0 captured at the load, each advance sets `word_addr[1:0]` to the previous value plus 1, modulo 4. For example, base 1 gives 1,2,3,0.
- R5: With `order_sel`=1 captured at the load, beat k (k=0 at the load) gives `word_addr[1:0]` = base[1:0] XOR (k mod 4). For example, base 1 gives 1,0,3,2.
- R6: During a burst, `word_addr[ADDR_W-1:2]` never changes. An advance past four beats repeats the wrapped sequence.
- R7: `acc_write` equals the inverse of `wr_en_n` sampled at the load edge. Advances ignore `wr_en_n` and `sel_act`, and they keep both `acc_write` and `burst_act`.
- R8: At an edge with `clk_en_n`=1, `word_addr`, `acc_write` and `burst_act` keep their values, whatever the other inputs are.
- R9: An advance when no burst is active (after reset or after a deselect) leaves `burst_act` at 0.
- R10: The burst order is captured at the load. A change of `order_sel` during the burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; when high all state holds |
| adv_nload | input | 1 | 1 = advance the burst, 0 = load a new address |
| sel_act | input | NUM_SEL | Chip selects, active high; all must be 1 for a load |
| wr_en_n | input | 1 | Write enable, active low; sampled at a load only |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order; sampled at a load only |
| addr_in | input | ADDR_W | Base word address |
| word_addr | output | ADDR_W | Current word address |
| acc_write | output | 1 | 1 = the current burst is a write |
| burst_act | output | 1 | 1 = a valid burst is in progress |

## Verification
Two pairs of functions can fall in the same cycle:
- A clock-enable stall can arrive together with a load or an advance command.
- An advance can arrive together with deselected chip selects and a toggled write enable.

The bench provokes both pairs. It drives a stall with the strobe low and a fresh address on `addr_in`, and expects no change at the outputs. It drives advances with `sel_act` all zero and `wr_en_n` flipped, and expects the burst to step with its type unchanged. A behavioural model with unbounded beat counts, reduced modulo 4, judges every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_DESEL = 2'd2,
        CMD_STEP  = 2'd3
    } cmd_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTERLV = 1'b1
    } order_e;

endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
    import burst_seq_pkg::*;
#(
    parameter int NUM_SEL = 3
) (
    input  logic               clk_en_n,
    input  logic               adv_nload,
    input  logic [NUM_SEL-1:0] sel_act,
    output cmd_e               cmd
);

    logic all_sel;

    assign all_sel = &sel_act;

    always_comb begin
        if (clk_en_n) begin
            cmd = CMD_IDLE;
        end else if (adv_nload) begin
            cmd = CMD_STEP;
        end else if (all_sel) begin
            cmd = CMD_LOAD;
        end else begin
            cmd = CMD_DESEL;
        end
    end

endmodule

// File: rtl/bas_low_gen.sv
module bas_low_gen
    import burst_seq_pkg::*;
#(
    parameter int LOW_W = BEAT_W
) (
    input  logic [LOW_W-1:0] base_lo,
    input  logic [LOW_W-1:0] beat,
    input  order_e           ord,
    output logic [LOW_W-1:0] lo
);

    logic [LOW_W-1:0] lin;
    logic [LOW_W-1:0] ilv;

    assign lin = base_lo + beat;

    for (genvar i = 0; i < LOW_W; i++) begin : g_ilv
        assign ilv[i] = base_lo[i] ^ beat[i];
    end

    assign lo = (ord == ORD_INTERLV) ? ilv : lin;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int NUM_SEL = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_en_n,
    input  logic               adv_nload,
    input  logic [NUM_SEL-1:0] sel_act,
    input  logic               wr_en_n,
    input  logic               order_sel,
    input  logic [ADDR_W-1:0]  addr_in,
    output logic [ADDR_W-1:0]  word_addr,
    output logic               acc_write,
    output logic               burst_act
);

    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        logic              wr;
        order_e            ord;
        logic              act;
    } seq_t;

    cmd_e              cmd;
    seq_t              st_d;
    seq_t              st_q;
    logic [BEAT_W-1:0] beat_inc_d;
    logic [BEAT_W-1:0] low_q;
    logic [HI_W-1:0]   hi_q;

    bas_cmd_decode #(.NUM_SEL(NUM_SEL)) u_dec (
        .clk_en_n (clk_en_n),
        .adv_nload(adv_nload),
        .sel_act  (sel_act),
        .cmd      (cmd)
    );

    assign beat_inc_d = st_q.beat + {{(BEAT_W-1){1'b0}}, 1'b1};

    always_comb begin
        st_d = st_q;
        case (cmd)
            CMD_LOAD: begin
                st_d.base = addr_in;
                st_d.beat = '0;
                st_d.wr   = ~wr_en_n;
                st_d.ord  = order_sel ? ORD_INTERLV : ORD_LINEAR;
                st_d.act  = 1'b1;
            end
            CMD_DESEL: begin
                st_d.act = 1'b0;
            end
            CMD_STEP: begin
                if (st_q.act) begin
                    st_d.beat = beat_inc_d;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{base: '0, beat: '0, wr: 1'b0, ord: ORD_LINEAR, act: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    bas_low_gen #(.LOW_W(BEAT_W)) u_low (
        .base_lo(st_q.base[BEAT_W-1:0]),
        .beat   (st_q.beat),
        .ord    (st_q.ord),
        .lo     (low_q)
    );

    assign hi_q      = st_q.base[ADDR_W-1:BEAT_W];
    assign word_addr = {hi_q, low_q};
    assign acc_write = st_q.wr;
    assign burst_act = st_q.act;

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
    parameter int ADDR_W  = 17,
    parameter int NUM_SEL = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clk_en_n,
    input logic               adv_nload,
    input logic [NUM_SEL-1:0] sel_act,
    input logic               wr_en_n,
    input logic               order_sel,
    input logic [ADDR_W-1:0]  addr_in,
    input logic [ADDR_W-1:0]  word_addr,
    input logic               acc_write,
    input logic               burst_act
);

    logic is_load;
    logic is_desel;
    logic is_step;
    logic ord_seen;

    assign is_load  = !clk_en_n && !adv_nload && (&sel_act);
    assign is_desel = !clk_en_n && !adv_nload && !(&sel_act);
    assign is_step  = !clk_en_n && adv_nload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ord_seen <= 1'b0;
        end else if (is_load) begin
            ord_seen <= order_sel;
        end
    end

    AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (burst_act && word_addr == $past(addr_in))) else $error("load"); // R2

    AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        is_desel |=> !burst_act) else $error("deselect"); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && burst_act && !ord_seen) |=>
            (word_addr[1:0] == $past(word_addr[1:0]) + 2'd1)) else $error("linear"); // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && burst_act) |=>
            (word_addr[ADDR_W-1:2] == $past(word_addr[ADDR_W-1:2]))) else $error("upper"); // R6

    AST_TYPE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> (acc_write == !$past(wr_en_n))) else $error("type at load"); // R7

    AST_TYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && burst_act) |=> (burst_act && $stable(acc_write))) else $error("type kept"); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(word_addr) && $stable(acc_write) && $stable(burst_act)))
        else $error("stall"); // R8

    AST_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_step && !burst_act) |=> !burst_act) else $error("wake"); // R9

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_n (clk_en_n),
    .adv_nload(adv_nload),
    .sel_act  (sel_act),
    .wr_en_n  (wr_en_n),
    .order_sel(order_sel),
    .addr_in  (addr_in),
    .word_addr(word_addr),
    .acc_write(acc_write),
    .burst_act(burst_act)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/100ps
module burst_addr_seq_bench;

    localparam int AW = 17;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          adv_nload = 1'b1;
    logic [NS-1:0] sel_act = '0;
    logic          wr_en_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] word_addr;
    logic          acc_write;
    logic          burst_act;

    int checks = 0;
    int errors = 0;

    int m_base = 0;
    int m_beat = 0;
    int m_wr   = 0;
    int m_ord  = 0;
    int m_act  = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .NUM_SEL(NS)) u_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_nload(adv_nload),
        .sel_act(sel_act), .wr_en_n(wr_en_n), .order_sel(order_sel),
        .addr_in(addr_in), .word_addr(word_addr), .acc_write(acc_write),
        .burst_act(burst_act)
    );

    function automatic int exp_addr();
        int lo;
        if (m_ord == 1) lo = (m_base % 4) ^ (m_beat % 4);
        else            lo = ((m_base % 4) + m_beat) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check_val({tag, " burst_act"}, int'(burst_act), m_act);
        if (m_act == 1) begin
            check_val({tag, " word_addr"}, int'(word_addr), exp_addr());
            check_val({tag, " acc_write"}, int'(acc_write), m_wr);
        end
    endtask

    task automatic step(input logic cen, input logic adv, input logic [NS-1:0] sel,
                        input logic wen, input logic ord, input int addr, input string tag);
        @(negedge clk);
        clk_en_n  = cen;
        adv_nload = adv;
        sel_act   = sel;
        wr_en_n   = wen;
        order_sel = ord;
        addr_in   = AW'(addr);
        @(posedge clk);
        if (!cen) begin
            if (!adv) begin
                if (&sel) begin
                    m_base = addr;
                    m_beat = 0;
                    m_wr   = wen ? 0 : 1;
                    m_ord  = ord ? 1 : 0;
                    m_act  = 1;
                end else begin
                    m_act = 0;
                end
            end else if (m_act == 1) begin
                m_beat = m_beat + 1;
            end
        end
        #1;
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_val("R1 reset burst_act", int'(burst_act), 0);
        check_val("R1 reset acc_write", int'(acc_write), 0);
        check_val("R1 reset word_addr", int'(word_addr), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // advance before any load
        step(0, 1, 3'b111, 0, 0, 0, "R9 advance after reset");
        step(0, 1, 3'b000, 1, 1, 0, "R9 advance after reset");

        // linear read burst, continued past four beats
        step(0, 0, 3'b111, 1, 0, 'h1A5C1, "R2 load linear");
        for (int i = 0; i < 6; i++) step(0, 1, 3'b111, 1, 0, 'h00000, "R4 R6 linear advance");

        // interleaved write burst, advances with selects low and write enable flipped
        step(0, 0, 3'b111, 0, 1, 'h0F3E5, "R2 R7 load interleaved write");
        step(0, 1, 3'b000, 1, 1, 'h1FFFF, "R5 R7 advance ignores selects and we");
        step(0, 1, 3'b010, 0, 1, 'h00000, "R5 R7 advance ignores selects and we");
        step(0, 1, 3'b000, 1, 0, 'h12345, "R10 order change mid burst");
        step(0, 1, 3'b101, 1, 0, 'h12345, "R10 R6 order change mid burst");
        step(0, 1, 3'b000, 0, 0, 'h00000, "R5 R6 past four beats");

        // stall colliding with a load and with an advance
        step(1, 0, 3'b111, 1, 0, 'h00002, "R8 stall with load strobe");
        step(1, 1, 3'b111, 0, 1, 'h00003, "R8 stall with advance");
        step(1, 0, 3'b000, 0, 0, 'h00004, "R8 stall with deselect");
        step(0, 1, 3'b111, 1, 0, 'h00000, "R5 advance after stall");

        // deselect by a single inactive select, then advances
        step(0, 0, 3'b011, 0, 0, 'h00007, "R3 deselect one select low");
        step(0, 1, 3'b111, 0, 0, 'h00000, "R9 advance after deselect");
        step(0, 1, 3'b111, 1, 1, 'h00000, "R9 advance after deselect");
        step(0, 0, 3'b111, 1, 1, 'h1FFFE, "R2 reload after deselect");
        step(0, 0, 3'b110, 1, 0, 'h00001, "R3 deselect during burst");
        step(0, 1, 3'b111, 1, 0, 'h00000, "R9 advance after deselect");

        // every base offset in both orders
        for (int o = 0; o < 2; o++) begin
            for (int b = 0; b < 4; b++) begin
                step(0, 0, 3'b111, logic'(b % 2), logic'(o), 'h15550 + b, "R2 sweep load");
                for (int k = 0; k < 5; k++) begin
                    step(0, 1, 3'b111, logic'(k % 2), logic'(1 - o), 'h0AAAA,
                         o == 1 ? "R5 R6 interleaved sweep" : "R4 R6 linear sweep");
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule